// File: doc/BRIEF.md
# PCI Host Aperture and Configuration Decoder

This block sits between a 32-bit CPU bus and a PCI-like target bus on the host side. The CPU sees three regions: a bank of 64 control words, and two 64 MB aperture windows. Each aperture access is relocated by a per-aperture base register and becomes a downstream memory or I/O transaction. When the aperture's control word asks for it, the access is redirected into a 20-bit configuration space instead.

Configuration addressing is one-hot in the style of per-slot select lines. Slot i owns a 256-byte window at `(0x800 << (i/8)) + ((i%8) * 0x100)`. A configuration access that hits a present slot is forwarded with that slot's select bit raised. Any other configuration location reads as all ones and is never forwarded.

Downstream requests use a valid/ready handshake, followed by a response strobe that carries read data or acknowledges a write. The CPU access is stalled until the block returns a single-cycle acknowledge.

Top module: `pci_aperture_bridge`

## Requirements
- R1: After reset, `cpu_ack_o`, `ds_valid_o` and `cfg_sel_o` are zero, and every control word reads 0.
- R2: The 64 control words sit at 0x04000000..0x040000FF, with word index `cpu_addr_i[7:2]`. A write updates only the bytes whose `cpu_be_i` bit is set. A read returns the stored word.
- R3: Words 2 and 3 are the base registers of aperture 0 and aperture 1. Their bits [1:0] always read 0, whatever is written.
- R4: Aperture 0 spans 0x14000000..0x17FFFFFF and aperture 1 spans 0x18000000..0x1BFFFFFF. An access that is not redirected is translated to `base + (cpu_addr_i[25:2] * 4)`. It goes downstream as memory space (code 0) when that address is 0x80000000 or higher and outside the I/O window. Byte enables, write data and direction are passed through unchanged.
- R5: A translated address in 0xC0000000..0xC000FFFF goes downstream as I/O space (code 1), with 0xC0000000 subtracted.
- R6: A translated address below 0x80000000 is never forwarded. A read returns 0xFFFFFFFF and a write is dropped, and both are acknowledged.
- R7: Word 0 controls aperture 0 and word 1 controls aperture 1. Bit 0 enables configuration use and bits [3:1] hold the destination. When bit 0 is 1 and the destination is 0, the access goes to configuration space (code 2) at address `(cpu_addr_i[25:2] * 4) mod 2^20`. Any other setting keeps memory translation.
- R8: A configuration address whose bits [19:8] match slot i's window, with `slot_present_i[i]` set, is forwarded with `cfg_sel_o` one-hot at bit i. `cfg_sel_o` is zero whenever no configuration request is being presented.
- R9: A configuration address that hits no present slot is not forwarded. A read returns 0xFFFFFFFF and a write is dropped.
- R10: `ds_valid_o` and every request field stay stable until `ds_ready_i`. `cpu_ack_o` rises only after `ds_rsp_valid_i`, and a read returns `ds_rdata_i`.
- R11: CPU addresses outside the register bank and both apertures read 0xFFFFFFFF. Writes to them change nothing and create no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until acknowledge |
| cpu_we_i | input | 1 | 1 = write |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_be_i | input | 4 | CPU byte enables |
| cpu_ack_o | output | 1 | Single-cycle access completion |
| cpu_rdata_o | output | 32 | Read data, valid with acknowledge |
| slot_present_i | input | NSLOT | Slot population mask |
| ds_valid_o | output | 1 | Downstream request valid |
| ds_ready_i | input | 1 | Downstream request accepted |
| ds_we_o | output | 1 | Downstream write |
| ds_space_o | output | 2 | 0 memory, 1 I/O, 2 configuration |
| ds_addr_o | output | 32 | Downstream address |
| ds_wdata_o | output | 32 | Downstream write data |
| ds_be_o | output | 4 | Downstream byte enables |
| ds_rsp_valid_i | input | 1 | Response or write acknowledge |
| ds_rdata_i | input | 32 | Response read data |
| cfg_sel_o | output | NSLOT | One-hot slot select for configuration requests |

## Verification
Aperture traffic is run with several base values and control settings. These separate plain memory relocation, the I/O subtraction, and the redirect into configuration space. Base values are chosen so that the translated address lands exactly on the memory floor, one dword under it, and on both edges of the I/O window. Configuration offsets cover slots in both select groups, an absent slot, and a gap between windows, so that a wrong shift or group boundary shows up as a wrong select bit or a spurious request. The ready delay varies from access to access, so field stability and the acknowledge timing are observed under stalls.

// File: rtl/pab_pkg.sv
package pab_pkg;
  typedef enum logic [1:0] {SP_MEM = 2'd0, SP_IO = 2'd1, SP_CFG = 2'd2} space_e;
  typedef enum logic [1:0] {K_NONE, K_REG, K_DS, K_CFG} kind_e;

  typedef struct packed {
    kind_e       kind;
    space_e      space;
    logic [31:0] addr;
  } route_t;

  localparam int CTRL_IDX0 = 0;
  localparam int BASE_IDX0 = 2;
  localparam int NAPER     = 2;
endpackage

// File: rtl/pab_regbank.sv
module pab_regbank import pab_pkg::*; #(
  parameter int NREG = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [31:0]            wdata_i,
  input  logic [3:0]             be_i,
  output logic [31:0]            rdata_o,
  output logic [NAPER-1:0]       use_o,
  output logic [NAPER-1:0][2:0]  dest_o,
  output logic [NAPER-1:0][31:0] base_o
);
  logic [NREG-1:0][31:0] regs_q;
  logic [31:0] merged;
  logic        is_base;

  assign rdata_o = regs_q[idx_i];

  always_comb begin
    merged = regs_q[idx_i];
    for (int b = 0; b < 4; b++)
      if (be_i[b]) merged[8*b +: 8] = wdata_i[8*b +: 8];
    is_base = (int'(idx_i) >= BASE_IDX0) && (int'(idx_i) < BASE_IDX0 + NAPER);
    if (is_base) merged[1:0] = 2'b00;  // keep relocated addresses dword aligned
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   regs_q <= '0;
    else if (we_i) regs_q[idx_i] <= merged;
  end

  for (genvar a = 0; a < NAPER; a++) begin : g_ap
    assign use_o[a]  = regs_q[CTRL_IDX0 + a][0];
    assign dest_o[a] = regs_q[CTRL_IDX0 + a][3:1];
    assign base_o[a] = regs_q[BASE_IDX0 + a];
  end
endmodule

// File: rtl/pab_xlate.sv
module pab_xlate import pab_pkg::*; #(
  parameter logic [31:0] REG_BASE = 32'h0400_0000,
  parameter int          RB_AW    = 8,
  parameter logic [31:0] AP_BASE0 = 32'h1400_0000,
  parameter logic [31:0] AP_BASE1 = 32'h1800_0000,
  parameter int          AP_AW    = 26,
  parameter int          CFG_AW   = 20,
  parameter logic [31:0] MEM_LO   = 32'h8000_0000,
  parameter logic [31:0] IO_BASE  = 32'hC000_0000,
  parameter int          IO_AW    = 16
) (
  input  logic [31:0]            addr_i,
  input  logic [NAPER-1:0]       use_i,
  input  logic [NAPER-1:0][2:0]  dest_i,
  input  logic [NAPER-1:0][31:0] base_i,
  output route_t                 route_o
);
  localparam logic [31:0] OFF_MASK = 32'((64'd1 << AP_AW) - 64'd1);
  localparam logic [31:0] CFG_MASK = 32'((64'd1 << CFG_AW) - 64'd1);

  logic [31:0] a, off, ma;
  logic        hit0, hit1, sel;

  always_comb begin
    a    = addr_i & 32'hFFFF_FFFC;
    off  = a & OFF_MASK;
    hit0 = a[31:AP_AW] == AP_BASE0[31:AP_AW];
    hit1 = a[31:AP_AW] == AP_BASE1[31:AP_AW];
    sel  = hit1;
    ma   = base_i[sel] + off;
    route_o = '{kind: K_NONE, space: SP_MEM, addr: a};
    if (a[31:RB_AW] == REG_BASE[31:RB_AW]) begin
      route_o.kind = K_REG;
    end else if (hit0 || hit1) begin
      if (use_i[sel] && dest_i[sel] == 3'd0) begin
        route_o = '{kind: K_CFG, space: SP_CFG, addr: off & CFG_MASK};
      end else if (ma[31:IO_AW] == IO_BASE[31:IO_AW]) begin
        route_o = '{kind: K_DS, space: SP_IO, addr: ma - IO_BASE};
      end else if (ma >= MEM_LO) begin
        route_o = '{kind: K_DS, space: SP_MEM, addr: ma};
      end
    end
  end
endmodule

// File: rtl/pab_slot_dec.sv
module pab_slot_dec #(
  parameter int NSLOT  = 9,
  parameter int CFG_AW = 20
) (
  input  logic [CFG_AW-9:0] page_i,
  input  logic [NSLOT-1:0]  present_i,
  output logic [NSLOT-1:0]  hit_o
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    // group g = i/8 starts at 0x800 << g, slots 256 bytes apart inside it
    localparam logic [31:0] SLOT_BASE = (32'h800 << (i / 8)) + 32'((i % 8) * 256);
    assign hit_o[i] = present_i[i] && (page_i == SLOT_BASE[CFG_AW-1:8]);
  end
endmodule

// File: rtl/pci_aperture_bridge.sv
module pci_aperture_bridge import pab_pkg::*; #(
  parameter int          NREG     = 64,
  parameter int          NSLOT    = 9,
  parameter int          CFG_AW   = 20,
  parameter logic [31:0] REG_BASE = 32'h0400_0000,
  parameter logic [31:0] AP_BASE0 = 32'h1400_0000,
  parameter logic [31:0] AP_BASE1 = 32'h1800_0000,
  parameter int          AP_AW    = 26,
  parameter logic [31:0] MEM_LO   = 32'h8000_0000,
  parameter logic [31:0] IO_BASE  = 32'hC000_0000,
  parameter int          IO_AW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [31:0]      cpu_addr_i,
  input  logic [31:0]      cpu_wdata_i,
  input  logic [3:0]       cpu_be_i,
  output logic             cpu_ack_o,
  output logic [31:0]      cpu_rdata_o,
  input  logic [NSLOT-1:0] slot_present_i,
  output logic             ds_valid_o,
  input  logic             ds_ready_i,
  output logic             ds_we_o,
  output logic [1:0]       ds_space_o,
  output logic [31:0]      ds_addr_o,
  output logic [31:0]      ds_wdata_o,
  output logic [3:0]       ds_be_o,
  input  logic             ds_rsp_valid_i,
  input  logic [31:0]      ds_rdata_i,
  output logic [NSLOT-1:0] cfg_sel_o
);
  localparam int RIW   = $clog2(NREG);
  localparam int RB_AW = RIW + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} st_e;

  st_e                    st_q;
  logic [NAPER-1:0]       ap_use;
  logic [NAPER-1:0][2:0]  ap_dest;
  logic [NAPER-1:0][31:0] ap_base;
  logic [31:0]            reg_rdata;
  route_t                 rt;
  logic [NSLOT-1:0]       slot_hit;
  logic                   accept, reg_we;

  space_e           q_space;
  logic [31:0]      q_addr, q_wdata, q_rdata;
  logic [3:0]       q_be;
  logic             q_we;
  logic [NSLOT-1:0] q_sel;

  assign accept = (st_q == ST_IDLE) && cpu_req_i;
  assign reg_we = accept && cpu_we_i && (rt.kind == K_REG);

  pab_regbank #(.NREG(NREG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .idx_i   (cpu_addr_i[RB_AW-1:2]),
    .wdata_i (cpu_wdata_i),
    .be_i    (cpu_be_i),
    .rdata_o (reg_rdata),
    .use_o   (ap_use),
    .dest_o  (ap_dest),
    .base_o  (ap_base)
  );

  pab_xlate #(
    .REG_BASE(REG_BASE), .RB_AW(RB_AW), .AP_BASE0(AP_BASE0), .AP_BASE1(AP_BASE1),
    .AP_AW(AP_AW), .CFG_AW(CFG_AW), .MEM_LO(MEM_LO), .IO_BASE(IO_BASE), .IO_AW(IO_AW)
  ) u_xlate (
    .addr_i  (cpu_addr_i),
    .use_i   (ap_use),
    .dest_i  (ap_dest),
    .base_i  (ap_base),
    .route_o (rt)
  );

  pab_slot_dec #(.NSLOT(NSLOT), .CFG_AW(CFG_AW)) u_slots (
    .page_i    (rt.addr[CFG_AW-1:8]),
    .present_i (slot_present_i),
    .hit_o     (slot_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      q_space <= SP_MEM;
      q_addr  <= '0;
      q_wdata <= '0;
      q_rdata <= '0;
      q_be    <= '0;
      q_we    <= 1'b0;
      q_sel   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          q_space <= rt.space;
          q_addr  <= rt.addr;
          q_wdata <= cpu_wdata_i;
          q_be    <= cpu_be_i;
          q_we    <= cpu_we_i;
          q_sel   <= (rt.kind == K_CFG) ? slot_hit : '0;
          q_rdata <= '1;
          if (rt.kind == K_REG) begin
            q_rdata <= reg_rdata;
            st_q    <= ST_RESP;
          end else if (rt.kind == K_DS || (rt.kind == K_CFG && |slot_hit)) begin
            st_q    <= ST_ISSUE;
          end else begin
            st_q    <= ST_RESP;
          end
        end
        ST_ISSUE: if (ds_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (ds_rsp_valid_i) begin
          q_rdata <= ds_rdata_i;
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ack_o   = (st_q == ST_RESP);
  assign cpu_rdata_o = q_rdata;
  assign ds_valid_o  = (st_q == ST_ISSUE);
  assign ds_we_o     = q_we;
  assign ds_space_o  = q_space;
  assign ds_addr_o   = q_addr;
  assign ds_wdata_o  = q_wdata;
  assign ds_be_o     = q_be;
  assign cfg_sel_o   = ds_valid_o ? q_sel : '0;
endmodule

// File: rtl/pab_checker.sv
module pab_checker #(
  parameter int NSLOT = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_ack_o,
  input logic             ds_valid_o,
  input logic             ds_ready_i,
  input logic [1:0]       ds_space_o,
  input logic [31:0]      ds_addr_o,
  input logic [31:0]      ds_wdata_o,
  input logic [3:0]       ds_be_o,
  input logic [NSLOT-1:0] cfg_sel_o
);
  a_r10_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_valid_o && !ds_ready_i |=> ds_valid_o && $stable(ds_addr_o) && $stable(ds_space_o)
                                  && $stable(ds_wdata_o) && $stable(ds_be_o));
  a_r10_drop_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_valid_o && ds_ready_i |=> !ds_valid_o);
  a_r10_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);
  a_r8_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_sel_o));
  a_r8_sel_only_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |cfg_sel_o |-> ds_valid_o && ds_space_o == 2'd2);
  a_r9_cfg_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_valid_o && ds_space_o == 2'd2 |-> $countones(cfg_sel_o) == 1);
  a_r6_mem_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_valid_o && ds_space_o == 2'd0 |-> ds_addr_o[31]);
  a_r5_io_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_valid_o && ds_space_o == 2'd1 |-> ds_addr_o[31:16] == 16'h0);
endmodule

bind pci_aperture_bridge pab_checker #(.NSLOT(NSLOT)) u_pab_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_ack_o  (cpu_ack_o),
  .ds_valid_o (ds_valid_o),
  .ds_ready_i (ds_ready_i),
  .ds_space_o (ds_space_o),
  .ds_addr_o  (ds_addr_o),
  .ds_wdata_o (ds_wdata_o),
  .ds_be_o    (ds_be_o),
  .cfg_sel_o  (cfg_sel_o)
);

// File: tb/tb_pci_aperture_bridge.sv
module tb_pci_aperture_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [3:0] cpu_be_i = '0;
  logic cpu_ack_o;
  logic [31:0] cpu_rdata_o;
  logic [NSLOT-1:0] slot_present_i = 9'h1F7;  // slot 3 absent
  logic ds_valid_o, ds_ready_i = 1'b0, ds_we_o;
  logic [1:0] ds_space_o;
  logic [31:0] ds_addr_o, ds_wdata_o;
  logic [3:0] ds_be_o;
  logic ds_rsp_valid_i = 1'b0;
  logic [31:0] ds_rdata_i = '0;
  logic [NSLOT-1:0] cfg_sel_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pci_aperture_bridge dut (.*);

  // reference state
  logic [31:0] mregs [64];
  logic [31:0] dsmem [logic [33:0]];
  int rdy_dly = 0;

  function automatic logic [31:0] ds_peek(logic [1:0] sp, logic [31:0] ad);
    if (dsmem.exists({sp, ad})) return dsmem[{sp, ad}];
    return ad ^ 32'h5A5A_0000 ^ {30'd0, sp};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // downstream target model
  initial begin
    forever begin
      @(negedge clk_i);
      if (ds_valid_o) begin
        repeat (rdy_dly) @(negedge clk_i);
        rdy_dly = (rdy_dly + 1) % 4;
        ds_ready_i = 1'b1;
        @(negedge clk_i);
        ds_ready_i = 1'b0;
        repeat (2) @(negedge clk_i);
        if (ds_we_o)
          dsmem[{ds_space_o, ds_addr_o}] = merge(ds_peek(ds_space_o, ds_addr_o), ds_wdata_o, ds_be_o);
        ds_rdata_i = ds_peek(ds_space_o, ds_addr_o);
        ds_rsp_valid_i = 1'b1;
        @(negedge clk_i);
        ds_rsp_valid_i = 1'b0;
      end
    end
  end

  // kind: 0 local none, 1 register, 2 forwarded
  task automatic ref_route(input logic [31:0] ad, output int kind, output logic [1:0] sp,
                           output logic [31:0] da, output logic [NSLOT-1:0] sel);
    logic [31:0] a = {ad[31:2], 2'b00};
    kind = 0; sp = 0; da = 0; sel = 0;
    if (a >= 32'h0400_0000 && a < 32'h0400_0100) kind = 1;
    else if (a >= 32'h1400_0000 && a < 32'h1C00_0000) begin
      int ap = (a >= 32'h1800_0000) ? 1 : 0;
      logic [31:0] off = a - (ap ? 32'h1800_0000 : 32'h1400_0000);
      logic [31:0] ctl = mregs[ap];
      if (ctl[0] && ctl[3:1] == 0) begin
        logic [31:0] ca = off % 32'h0010_0000;
        for (int i = 0; i < NSLOT; i++) begin
          logic [31:0] sb = (32'h800 << (i / 8)) + 32'((i % 8) * 256);
          if (slot_present_i[i] && ca >= sb && ca < sb + 256) begin
            kind = 2; sp = 2; da = ca; sel = NSLOT'(1) << i;
          end
        end
      end else begin
        logic [31:0] m = mregs[2 + ap] + off;
        if (m >= 32'hC000_0000 && m <= 32'hC000_FFFF) begin kind = 2; sp = 1; da = m - 32'hC000_0000; end
        else if (m >= 32'h8000_0000) begin kind = 2; sp = 0; da = m; end
      end
    end
  endtask

  task automatic acc(input logic we, input logic [31:0] ad, input logic [31:0] wd,
                     input logic [3:0] be, input string rq, output logic [31:0] rd);
    int kind, n;
    logic [1:0] sp;
    logic [31:0] da, exp_rd;
    logic [NSLOT-1:0] sel;
    bit seen = 0;
    ref_route(ad, kind, sp, da, sel);
    exp_rd = (kind == 1) ? mregs[ad[7:2]] : (kind == 2) ? ds_peek(sp, da) : 32'hFFFF_FFFF;
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = ad; cpu_wdata_i = wd; cpu_be_i = be;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (ds_valid_o) begin
        seen = 1;
        chk(kind == 2, {rq, " unexpected request"}, 32'(ds_valid_o), 32'(kind == 2));
        chk(ds_space_o == sp, {rq, " space"}, 32'(ds_space_o), 32'(sp));
        chk(ds_addr_o == da, {rq, " addr"}, ds_addr_o, da);
        chk(ds_be_o == be && ds_we_o == we, {rq, " be/we"}, {27'd0, ds_we_o, ds_be_o}, {27'd0, we, be});
        if (we) chk(ds_wdata_o == wd, {rq, " wdata"}, ds_wdata_o, wd);
        chk(cfg_sel_o == sel, {rq, " R8 sel"}, 32'(cfg_sel_o), 32'(sel));
      end else begin
        chk(cfg_sel_o == 0, "R8 sel idle", 32'(cfg_sel_o), 0);
      end
    end while (!cpu_ack_o && n < 100);
    chk(cpu_ack_o, {rq, " R10 ack timeout"}, 32'(cpu_ack_o), 1);
    cpu_req_i = 1'b0;
    rd = cpu_rdata_o;
    chk(seen == (kind == 2), {rq, " forward"}, 32'(seen), 32'(kind == 2));
    if (!we) chk(rd == exp_rd, {rq, " rdata"}, rd, exp_rd);
    if (we && kind == 1) begin
      mregs[ad[7:2]] = merge(mregs[ad[7:2]], wd, be);
      if (ad[7:2] == 2 || ad[7:2] == 3) mregs[ad[7:2]][1:0] = 2'b00;
    end
  endtask

  task automatic wr(logic [31:0] ad, logic [31:0] wd, logic [3:0] be, string rq);
    logic [31:0] d;
    acc(1'b1, ad, wd, be, rq, d);
  endtask

  task automatic rdc(logic [31:0] ad, string rq);
    logic [31:0] d;
    acc(1'b0, ad, 32'h0, 4'hF, rq, d);
  endtask

  localparam logic [31:0] RB = 32'h0400_0000;
  localparam logic [31:0] A0 = 32'h1400_0000;
  localparam logic [31:0] A1 = 32'h1800_0000;

  initial begin
    for (int i = 0; i < 64; i++) mregs[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(!cpu_ack_o && !ds_valid_o && cfg_sel_o == 0, "R1 outputs in reset",
        {cpu_ack_o, ds_valid_o, 30'(cfg_sel_o)}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cpu_ack_o && !ds_valid_o, "R1 outputs after reset", {cpu_ack_o, ds_valid_o}, 0);
    for (int i = 0; i < 4; i++) rdc(RB + 32'(4 * i), "R1 reg clear");
    rdc(RB + 32'hFC, "R1 reg clear top");

    // R2 register bank with byte enables
    wr(RB + 32'h28, 32'hDEAD_BEEF, 4'hF, "R2 full write");
    wr(RB + 32'h28, 32'h1122_3344, 4'b0101, "R2 partial write");
    rdc(RB + 32'h28, "R2 readback");
    wr(RB + 32'hFC, 32'hCAFE_F00D, 4'hF, "R2 last word");
    rdc(RB + 32'hFC, "R2 last readback");

    // R3 base alignment
    wr(RB + 32'h08, 32'h1234_5677, 4'hF, "R3 base0 write");
    rdc(RB + 32'h08, "R3 base0 low bits");
    wr(RB + 32'h0C, 32'hFFFF_FFFF, 4'hF, "R3 base1 write");
    rdc(RB + 32'h0C, "R3 base1 low bits");

    // R4 memory relocation
    wr(RB + 32'h08, 32'h8000_0000, 4'hF, "R4 base0");
    rdc(A0 + 32'h10, "R4 ap0 read");
    wr(A0 + 32'h10, 32'hA5A5_0F0F, 4'b0101, "R4 ap0 partial write");
    rdc(A0 + 32'h10, "R4 ap0 readback");
    rdc(A0 + 32'h03FF_FFFC, "R4 ap0 last dword");
    wr(RB + 32'h0C, 32'hA000_0000, 4'hF, "R4 base1");
    wr(RB + 32'h04, 32'h0000_0003, 4'hF, "R7 ctrl1 dest 1");
    rdc(A1 + 32'h0000_1234, "R7 dest nonzero keeps memory");
    wr(A1 + 32'h40, 32'h0BAD_CAFE, 4'hF, "R4 ap1 write");
    rdc(A1 + 32'h40, "R4 ap1 readback");

    // R5 I/O window edges
    wr(RB + 32'h08, 32'hC000_0000, 4'hF, "R5 base0 io");
    rdc(A0 + 32'h0000_0010, "R5 io low");
    rdc(A0 + 32'h0000_FFFC, "R5 io top edge");
    rdc(A0 + 32'h0001_0000, "R5 just above io is memory");
    wr(RB + 32'h08, 32'hBFFF_FF00, 4'hF, "R5 base0 below io");
    rdc(A0 + 32'h0000_00FC, "R5 under io is memory");
    rdc(A0 + 32'h0000_0110, "R5 io via offset");

    // R6 memory floor
    wr(RB + 32'h08, 32'h7FFF_FFF0, 4'hF, "R6 base0 low");
    rdc(A0 + 32'h0000_000C, "R6 below floor read");
    wr(A0 + 32'h0000_000C, 32'h1111_1111, 4'hF, "R6 below floor write dropped");
    rdc(A0 + 32'h0000_0010, "R6 floor forwarded");

    // R7 R8 R9 configuration redirect
    wr(RB + 32'h00, 32'h0000_0001, 4'hF, "R7 ctrl0 cfg");
    rdc(A0 + 32'h0000_0800, "R8 slot0");
    rdc(A0 + 32'h0000_0F04, "R8 slot7");
    rdc(A0 + 32'h0000_1000, "R8 slot8 second group");
    wr(A0 + 32'h0000_10FC, 32'h0055_AA00, 4'b0110, "R8 slot8 write");
    rdc(A0 + 32'h0000_10FC, "R8 slot8 readback");
    rdc(A0 + 32'h0000_0B00, "R9 absent slot3");
    wr(A0 + 32'h0000_0B00, 32'h2222_2222, 4'hF, "R9 absent slot write dropped");
    rdc(A0 + 32'h0000_1100, "R9 gap after slot8");
    rdc(A0 + 32'h0000_0000, "R9 below slot0");
    rdc(A0 + 32'h0010_0900, "R7 20-bit wrap to slot1");
    wr(RB + 32'h04, 32'h0000_0001, 4'hF, "R7 ctrl1 cfg");
    rdc(A1 + 32'h0000_0C08, "R7 ap1 redirect slot4");
    slot_present_i = 9'h1FF;
    rdc(A0 + 32'h0000_0B00, "R8 slot3 now present");

    // R11 unmapped CPU space
    rdc(32'h2000_0000, "R11 read unmapped");
    wr(32'h0000_0000, 32'h3333_3333, 4'hF, "R11 write unmapped");
    wr(32'h1C00_0000, 32'h4444_4444, 4'hF, "R11 above apertures");
    rdc(RB + 32'h00, "R11 regs untouched");
    rdc(RB + 32'h28, "R11 regs untouched 2");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule